// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM that stores 16-bit words behind a 19-bit word address. The host hands over one request at a time on a valid/ready port: a read, or a write with a two-bit byte mask. The controller then produces the RAM's pin sequence: address, active-low chip, output and write enables, and active-low strobes for the low and high byte lanes. The bidirectional data pin is presented as a split bus: data out, data in, and an output-enable for a pad buffer that sits outside the block.

The RAM has no clock, so every phase of a cycle is a number of controller clocks. That number is derived at elaboration time from nanosecond timing parameters and the clock period. A read holds the chip and output enables low until the access time has passed, registers the word and masks off lanes that were not requested. It then waits out the RAM's output release time before any later write may drive the bus. A write first presents address and data with write enable high. It then pulses write enable low for the required width and holds everything through a recovery phase, so that the whole cycle meets the minimum cycle time.

Top module: `sram_cycle_ctl`

## Requirements
- R1: While reset is high and afterwards while idle, chip, output and write enables and both lane strobes are high (inactive), the data output-enable is low, and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready then stays low until the controller is idle again. At default parameters that is 8 cycles after acceptance for a write and 13 cycles after for a read.
- R3: A read holds chip and output enables low with write enable high for the access phase, registers the data-in bus on its last cycle, and presents it on rsp_rdata with rsp_done high in cycle 8 after acceptance at default parameters.
- R4: req_be bit 0 enables the low lane (data bits 7:0, low-lane strobe) and bit 1 enables the high lane (bits 15:8, high-lane strobe) for both reads and writes. A disabled lane is not written, and it reads back as zero.
- R5: A write takes one setup cycle with write enable high and address, lanes and data driven, then the write pulse, then recovery with write enable high. rsp_done is high in cycle 8 after acceptance at default parameters.
- R6: The address output changes only when write enable was high in both the previous and the current cycle.
- R7: Write enable low implies chip enable low and output enable high.
- R8: The data output-enable is high only while output enable is high, and it rises only after output enable has been high for at least the output release count (4 cycles at default parameters).
- R9: Each phase count is the ceiling of its time over the clock period, with a floor of one. The access phase uses the largest of address access, output-enable access and read cycle time, giving 7 cycles. The write pulse uses the larger of pulse width and data setup, giving 4 cycles. Recovery is stretched so that setup, pulse and recovery together cover the write cycle time, giving 2 cycles.
- R10: rsp_done is a single-cycle pulse for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 19 | RAM address pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_lb_n | output | 1 | Low-lane strobe, active low |
| sram_ub_n | output | 1 | High-lane strobe, active low |
| sram_dq_out | output | 16 | Data toward the pad buffer |
| sram_dq_oe | output | 1 | Pad buffer drive enable |
| sram_dq_in | input | 16 | Data from the pad buffer |

## Verification
Cycles are counted from the edge that accepts a request. At defaults a read completes in cycle 8 and is idle again in cycle 13, and a write completes and is idle in cycle 8. The bench derives these numbers from the timing parameters with its own arithmetic, samples at the falling edge of each cycle after acceptance, and records the first cycle in which done and ready appear. It also counts how many cycles write enable, chip enable and output enable spend low. A behavioural RAM model in the bench measures elapsed time in nanoseconds. It returns junk until the access time has passed, drives junk on unselected lanes, keeps driving for the release time after output enable rises, and counts every violation of pulse width, data setup, address stability or bus contention.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctl_state_t;

  // ceiling of t over period, never below one cycle
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctl_pkg::*;
(
  input  ctl_state_t       state,
  input  logic [LANES-1:0] be,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_oe
);
  logic rd_phase, wr_phase;

  assign rd_phase = (state == ST_RD_ACCESS);
  assign wr_phase = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                    (state == ST_WR_RECOVER);

  assign ce_n  = !(rd_phase || wr_phase);
  assign oe_n  = !rd_phase;
  assign we_n  = (state != ST_WR_PULSE);
  assign dq_oe = wr_phase;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = !((rd_phase || wr_phase) && be[g]);
  end
endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 19,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 30,
  parameter int T_DW_NS       = 25,
  parameter int T_AS_NS       = 0,
  parameter int T_WR_NS       = 0,
  parameter int T_OHZ_NS      = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [15:0]       sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_in
);
  // phase lengths in clock cycles
  localparam int N_ACC = max2(max2(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                   ns_to_cycles(T_OE_NS, CLK_PERIOD_NS)),
                              ns_to_cycles(T_RC_NS, CLK_PERIOD_NS));
  localparam int N_SET = ns_to_cycles(T_AS_NS, CLK_PERIOD_NS);
  localparam int N_WP  = max2(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                              ns_to_cycles(T_DW_NS, CLK_PERIOD_NS));
  localparam int N_WC  = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int N_REC = max2(ns_to_cycles(T_WR_NS, CLK_PERIOD_NS), N_WC - N_SET - N_WP);
  localparam int N_OHZ = ns_to_cycles(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int N_MAX = max2(max2(N_ACC, N_SET), max2(max2(N_WP, N_REC), N_OHZ));
  localparam int CNT_W = max2($clog2(N_MAX + 1), 1);
  localparam int CW1   = CNT_W + 1;

  localparam logic [CNT_W-1:0] C_ACC = CNT_W'(N_ACC - 1);
  localparam logic [CNT_W-1:0] C_SET = CNT_W'(N_SET - 1);
  localparam logic [CNT_W-1:0] C_WP  = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] C_REC = CNT_W'(N_REC - 1);
  localparam logic [CNT_W-1:0] C_OHZ = CNT_W'(N_OHZ - 1);

  ctl_state_t        state_q, state_d;
  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q, rdata_q, lane_mask;
  logic [1:0]        be_q, lane_n;
  logic              done_q;

  // named events used by the assertions
  logic accept, rd_last, wr_last;
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign rd_last = (state_q == ST_RD_ACCESS) && tmr_last;
  assign wr_last = (state_q == ST_WR_RECOVER) && tmr_last;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin state_d = ST_WR_SETUP;  tmr_val = C_SET; end
        else           begin state_d = ST_RD_ACCESS; tmr_val = C_ACC; end
      end
      ST_RD_ACCESS:  if (tmr_last) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin state_d = ST_TURNAROUND; tmr_load = 1'b1; tmr_val = C_OHZ; end
      ST_TURNAROUND: if (tmr_last) state_d = ST_IDLE;
      ST_WR_SETUP:   if (tmr_last) begin state_d = ST_WR_PULSE; tmr_load = 1'b1; tmr_val = C_WP; end
      ST_WR_PULSE:   if (tmr_last) begin state_d = ST_WR_RECOVER; tmr_load = 1'b1; tmr_val = C_REC; end
      ST_WR_RECOVER: if (tmr_last) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= rd_last || wr_last;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (rd_last) rdata_q <= sram_dq_in & lane_mask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  sram_pin_decode u_pins (
    .state(state_q), .be(be_q), .ce_n(sram_ce_n), .oe_n(sram_oe_n),
    .we_n(sram_we_n), .lane_n(lane_n), .dq_oe(sram_dq_oe)
  );

  assign sram_lb_n   = lane_n[0];
  assign sram_ub_n   = lane_n[1];
  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_done    = done_q;
  assign rsp_rdata   = rdata_q;

  // ---------------- checker state and assertions ----------------
  logic [CW1-1:0] we_low_cnt, oe_high_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= CW1'(N_OHZ);
    end else begin
      we_low_cnt  <= sram_we_n ? '0 : we_low_cnt + 1'b1;
      if (!sram_oe_n)                   oe_high_cnt <= '0;
      else if (oe_high_cnt < CW1'(N_OHZ)) oe_high_cnt <= oe_high_cnt + 1'b1;
    end
  end

  // R9
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_low_cnt >= CW1'(N_WP)));
  // R8
  bus_turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (oe_high_cnt >= CW1'(N_OHZ)));
  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);
  // R7
  we_ce_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));
  // R6
  addr_we_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sram_cycle_ctl_bench.sv
module sram_cycle_ctl_bench;
  localparam int P     = 8;
  localparam int T_AA  = 55, T_OE = 30, T_RC = 55, T_WC = 55;
  localparam int T_WP  = 30, T_DW = 25, T_OHZ = 25;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, sram_dq_out, sram_dq_in;
  logic [1:0]  req_be = '0;
  logic rsp_done, sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe;
  logic [18:0] sram_addr;

  always #4 clk = ~clk;  // 125 MHz

  sram_cycle_ctl u_sram_cycle_ctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // expected counts, found by stepping time forward one period at a time
  function automatic int span(input int t_ns);
    int n = 1;
    while (n * P < t_ns) n++;
    return n;
  endfunction
  function automatic int big(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  int e_acc, e_wp, e_rec, e_ohz;
  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural RAM with timing checks ----------------
  logic [15:0] mem [int];
  int addr_age = 0, oe_age = 0, we_len = 0, dstab = 0, hold = 0, viol = 0;
  logic [18:0] last_addr = '0;
  logic [15:0] last_dq = '0, model_dout = 16'hDEAD;
  logic last_we_n = 1'b1;
  logic [1:0] w_lanes = '0;
  assign sram_dq_in = model_dout;

  function automatic logic [15:0] peek(input int a);
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      hold = 0; addr_age = 0; oe_age = 0; we_len = 0; dstab = 0;
      last_we_n = 1'b1; model_dout = 16'hDEAD;
    end else begin
      logic drive;
      logic [15:0] w;
      addr_age = (sram_addr == last_addr) ? addr_age + 1 : 1;
      oe_age   = (!sram_oe_n && !sram_ce_n) ? oe_age + 1 : 0;
      if (sram_dq_oe) dstab = (sram_dq_out == last_dq) ? dstab + 1 : 1;
      else            dstab = 0;
      drive = !sram_ce_n && !sram_oe_n && sram_we_n;
      if (drive) begin
        hold = span(T_OHZ);
        if (sram_dq_oe) viol++;
      end else if (hold > 0) begin
        if (sram_dq_oe) viol++;
        hold--;
      end
      if (!sram_ce_n && !sram_we_n) begin
        if (!last_we_n && sram_addr != last_addr) viol++;
        we_len  = last_we_n ? 1 : we_len + 1;
        w_lanes = {!sram_ub_n, !sram_lb_n};
        if (dstab * P < T_DW && !last_we_n) ; // measured at the end
      end else if (!last_we_n) begin
        if (we_len * P < T_WP) viol++;
        if ((dstab - 1) * P < T_DW) viol++;
        w = peek(int'(last_addr));
        if (w_lanes[0]) w[7:0]  = last_dq[7:0];
        if (w_lanes[1]) w[15:8] = last_dq[15:8];
        mem[int'(last_addr)] = w;
      end
      if (drive && addr_age * P >= T_AA && oe_age * P >= T_OE) begin
        w = peek(int'(sram_addr));
        model_dout = {sram_ub_n ? 8'hA5 : w[15:8], sram_lb_n ? 8'h5A : w[7:0]};
      end else begin
        model_dout = 16'hDEAD;
      end
      last_addr = sram_addr;
      last_dq   = sram_dq_out;
      last_we_n = sram_we_n;
    end
  end

  // ---------------- request task ----------------
  int done_at, ready_at, done_cnt, we_low, ce_low, oe_low, oe_low_wr;
  logic [15:0] got;

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    done_at = 0; ready_at = 0; done_cnt = 0; we_low = 0; ce_low = 0;
    oe_low = 0; oe_low_wr = 0; got = 16'hxxxx;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_done) begin
        done_cnt++;
        if (done_at == 0) begin done_at = k; got = rsp_rdata; end
      end
      if (req_ready && ready_at == 0) ready_at = k;
      if (!sram_we_n) we_low++;
      if (!sram_ce_n) ce_low++;
      if (!sram_oe_n) oe_low++;
      if (!sram_oe_n && wr) oe_low_wr++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(sram_ce_n && sram_oe_n && sram_we_n, "R1 enables idle", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    check(sram_lb_n && sram_ub_n && !sram_dq_oe, "R1 lanes/drive idle", {sram_lb_n, sram_ub_n, sram_dq_oe}, 3'b110);
    check(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_full_word;
    do_req(1'b1, 19'h12345, 16'hA5C3, 2'b11);
    check(done_at == 1 + e_wp + e_rec + 1, "R5 write done cycle", done_at, 1 + e_wp + e_rec + 1);
    check(ready_at == done_at, "R2 write ready cycle", ready_at, done_at);
    check(we_low == e_wp, "R9 write pulse cycles", we_low, e_wp);
    check(ce_low == 1 + e_wp + e_rec, "R9 write ce cycles", ce_low, 1 + e_wp + e_rec);
    check(oe_low_wr == 0, "R7 oe high during write", oe_low_wr, 0);
    check(done_cnt == 1, "R10 write done pulses", done_cnt, 1);
    do_req(1'b0, 19'h12345, 16'h0, 2'b11);
    check(got == 16'hA5C3, "R3 read data", got, 16'hA5C3);
    check(done_at == e_acc + 1, "R3 read done cycle", done_at, e_acc + 1);
    check(ready_at == e_acc + 1 + e_ohz + 1, "R2 read ready cycle", ready_at, e_acc + e_ohz + 2);
    check(oe_low == e_acc, "R9 access cycles", oe_low, e_acc);
    check(done_cnt == 1, "R10 read done pulses", done_cnt, 1);
  endtask

  task automatic t_lanes;
    do_req(1'b1, 19'h00777, 16'h1111, 2'b11);
    do_req(1'b1, 19'h00777, 16'hEE22, 2'b01);  // low lane only
    do_req(1'b1, 19'h00777, 16'h33DD, 2'b10);  // high lane only
    do_req(1'b0, 19'h00777, 16'h0, 2'b11);
    check(got == 16'h3322, "R4 masked writes merge", got, 16'h3322);
    do_req(1'b0, 19'h00777, 16'h0, 2'b01);
    check(got == 16'h0022, "R4 high lane reads zero", got, 16'h0022);
    do_req(1'b0, 19'h00777, 16'h0, 2'b10);
    check(got == 16'h3300, "R4 low lane reads zero", got, 16'h3300);
  endtask

  task automatic t_edges;
    do_req(1'b1, 19'h00000, 16'h0F0F, 2'b11);
    do_req(1'b1, 19'h7FFFF, 16'hF0F0, 2'b11);
    do_req(1'b0, 19'h00000, 16'h0, 2'b11);
    check(got == 16'h0F0F, "R3 lowest address", got, 16'h0F0F);
    do_req(1'b0, 19'h7FFFF, 16'h0, 2'b11);
    check(got == 16'hF0F0, "R3 highest address", got, 16'hF0F0);
  endtask

  task automatic t_timing;
    check(viol == 0, "R6 R8 R9 model timing violations", viol, 0);
  endtask

  initial begin
    e_acc = big(big(span(T_AA), span(T_OE)), span(T_RC));
    e_wp  = big(span(T_WP), span(T_DW));
    e_rec = big(1, span(T_WC) - 1 - e_wp);
    e_ohz = span(T_OHZ);
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_lanes();
    t_edges();
    t_timing();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule